// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor-side bus controller for an 8-bit CPU whose low address byte and data byte share one set of pins. The core hands it one request at a time (read, write or interrupt acknowledge, to memory or I/O space, with a 16-bit address and write data). The block then plays out a machine cycle of three or more bus T states. It emits the latch pulse for the low address byte, the status code, the high address byte and the active-low strobes. It also drives or floats the shared pins at half-clock points and returns the captured read byte.

The block runs from an internal clock at twice the bus rate. A phase bit, exported as the bus clock, splits every T state into a low first half and a high second half. A READY input stretches the second T state. A HOLD input takes the bus off the block at the start of the third T state, or at any T boundary while idle.

Top module: `mbus_seq`

## Requirements
- R1: After reset, `ale` is 0, all three strobes are 1, `ad_oe` is 0, `hlda` is 0, `bus_oe` is 1, `busy` is 0 and `done` is 0.
- R2: `ale` is high for exactly the first half of T1. Through T1, `ad_out` carries address bits [7:0] with `ad_oe` high. `a_hi` carries address bits [15:8]. `stat` holds 2'b10 for a read, 2'b01 for a write and 2'b11 for an acknowledge. `io_m` is 1 for I/O or acknowledge cycles.
- R3: The shared pins float (`ad_oe`=0) in the first half of T2. In a write they drive the write data from the second half of T2 through the end of T3, which is half a clock past the strobe's rise. In a read or acknowledge they stay floating.
- R4: Kind encoding is 2'b00 read, 2'b01 write and 2'b10 acknowledge. Only the matching strobe (`rd_n`, `wr_n` or `inta_n`) goes low. It goes low at the start of T2 and rises at the middle of T3, which is three internal clocks without wait states.
- R5: `ready` is sampled at the middle of T2. Each low sample repeats T2, which adds two internal clocks of strobe.
- R6: For reads and acknowledges, `rdata` takes the `ad_in` value present on the internal clock edge that ends the last T2 half, which is half a clock before the strobe rises.
- R7: `busy` rises on the clock after `req` is accepted and falls together with a one-clock `done` pulse issued when T3 ends. A `req` while `busy` is 1 starts no cycle.
- R8: `hold` is sampled when T3 begins. If it is high, `hlda` rises at the middle of T3 while the bus is still driven. On the next half, `bus_oe` and `ad_oe` are 0.
- R9: While held, `hlda` stays 1 and `bus_oe` stays 0. After `hold` falls, `hlda` drops at the next T boundary with `bus_oe` back at 1. A pending cycle's `ale` follows two internal clocks later.
- R10: When idle, a high `hold` at a T boundary is granted the same way as in T3: `hlda` rises half a clock later, and the bus floats after another half. It wins over a pending request.
- R11: `bclk` is 0 in the first half and 1 in the second half of every T state, so `ale` only occurs while `bclk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | One-clock cycle request from the core |
| req_kind | input | 2 | 00 read, 01 write, 10 acknowledge |
| req_io | input | 1 | 1 selects I/O space |
| req_addr | input | ADDR_W (16) | Cycle address |
| req_wdata | input | DATA_W (8) | Write data |
| busy | output | 1 | A request is held or in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | DATA_W (8) | Captured read or acknowledge byte |
| bclk | output | 1 | Bus clock (phase bit) |
| ale | output | 1 | Address latch enable |
| io_m | output | 1 | I/O (1) or memory (0) select |
| stat | output | 2 | Cycle status code |
| a_hi | output | ADDR_W-DATA_W (8) | High address byte |
| ad_out | output | DATA_W (8) | Shared pins, outgoing value |
| ad_oe | output | 1 | Shared pins drive enable |
| ad_in | input | DATA_W (8) | Shared pins, incoming value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| ready | input | 1 | Wait-state control |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant |
| bus_oe | output | 1 | Enable for address, status and control outputs |

## Verification
The bench builds the block with ADDR_W=16 and DATA_W=8. This puts the full 16-bit space within reach, including 0x0000 and 0xFFFF, and it makes the high and low address bytes distinct, so a swapped half shows up. The incoming data changes every half clock during a strobe. Because of that, a capture one edge early or late returns a different byte. Wait counts of zero to three exercise the repeated T2 in both read and write cycles.

// File: rtl/mbus_seq.sv
module mbus_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        req_kind,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bclk,
  output logic              ale,
  output logic              io_m,
  output logic [1:0]        stat,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  output logic              bus_oe
);
  localparam logic [1:0] K_WR  = 2'b01;
  localparam logic [1:0] K_ACK = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_HGNT, S_HOLD} st_t;

  st_t               st;
  logic              ph, pend, io_q, rdy_q, wrep, hold_seen;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  wire is_wr  = kind_q == K_WR;
  wire is_ack = kind_q == K_ACK;
  wire is_rd  = !is_wr && !is_ack;
  wire active = st == S_T1 || st == S_T2 || st == S_T3;
  wire strobe = st == S_T2 || (st == S_T3 && !ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= 1'b0;  pend <= 1'b0;  done <= 1'b0;
      kind_q <= '0;  io_q <= 1'b0;  addr_q <= '0;  wd_q <= '0;
      rdy_q <= 1'b0; wrep <= 1'b0;  hold_seen <= 1'b0;  rdata <= '0;
    end else begin
      ph   <= ~ph;
      done <= 1'b0;
      if (req && !pend) begin
        pend <= 1'b1;  kind_q <= req_kind;  io_q <= req_io;
        addr_q <= req_addr;  wd_q <= req_wdata;
      end
      case (st)
        S_IDLE:
          if (ph) begin
            if (hold) begin
              st <= S_HGNT;  hold_seen <= 1'b1;
            end else if (pend) begin
              st <= S_T1;  wrep <= 1'b0;
            end
          end
        S_T1: if (ph) st <= S_T2;
        S_T2:
          if (!ph) rdy_q <= ready;
          else if (rdy_q) begin
            st <= S_T3;
            hold_seen <= hold;
            if (!is_wr) rdata <= ad_in;
          end else wrep <= 1'b1;
        S_T3:
          if (ph) begin
            done <= 1'b1;  pend <= 1'b0;
            st <= hold_seen ? S_HOLD : S_IDLE;
          end
        S_HGNT: if (ph) st <= S_HOLD;
        S_HOLD:
          if (ph && !hold) begin
            st <= S_IDLE;  hold_seen <= 1'b0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = pend;
  assign bclk   = ph;
  assign ale    = st == S_T1 && !ph;
  assign stat   = !active ? 2'b00 : is_wr ? 2'b01 : is_ack ? 2'b11 : 2'b10;
  assign io_m   = io_q | is_ack;
  assign a_hi   = addr_q[ADDR_W-1:DATA_W];
  assign ad_out = st == S_T1 ? addr_q[DATA_W-1:0] : wd_q;
  assign ad_oe  = st == S_T1 || (is_wr && ((st == S_T2 && (ph || wrep)) || st == S_T3));
  assign rd_n   = !(strobe && is_rd);
  assign wr_n   = !(strobe && is_wr);
  assign inta_n = !(strobe && is_ack);
  assign hlda   = st == S_HOLD || ((st == S_T3 || st == S_HGNT) && ph && hold_seen);
  assign bus_oe = st != S_HOLD;

  AST_ALE_SHORT:   assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R2
  AST_ALE_ADDR:    assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe && bus_oe && !bclk); // R11
  AST_FLOAT_T2:    assert property (@(posedge clk) disable iff (!rst_n) $fell(ale) |=> !ad_oe); // R3
  AST_ONE_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) $countones({~rd_n, ~wr_n, ~inta_n}) <= 1); // R4
  AST_STROBE_MIN:  assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |=> !rd_n); // R4
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_GRANT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(hlda) |=> !bus_oe); // R8
  AST_HELD_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !bus_oe |-> hlda && !ad_oe && ale == 1'b0); // R9
endmodule

// File: tb/sim_mbus_seq.sv
`timescale 1ns/1ps
module sim_mbus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_io = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [1:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in;
  logic busy, done, bclk, ale, io_m, ad_oe, rd_n, wr_n, inta_n, hlda, bus_oe;
  logic [7:0] rdata, a_hi, ad_out;
  logic [1:0] stat;

  always #2.5 clk = ~clk;

  mbus_seq u0 (.clk, .rst_n, .req, .req_kind, .req_io, .req_addr, .req_wdata,
    .busy, .done, .rdata, .bclk, .ale, .io_m, .stat, .a_hi, .ad_out, .ad_oe,
    .ad_in, .rd_n, .wr_n, .inta_n, .ready, .hold, .hlda, .bus_oe);

  typedef struct packed {
    logic [1:0] kind; logic io; logic [15:0] addr; logic [7:0] wd; logic [3:0] waits;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_bad = 0, cyc = 0, ale_cnt = 0, sc = 0, wleft = 0;
  logic [7:0] cap_lo = '0, cap_hi = '0, wd_last = '0;
  logic [1:0] cap_stat = '0;
  logic [2:0] strb = '0;
  logic cap_io = 1'b0, float_ok = 1'b1, post_ok = 1'b1, prev_low = 1'b0, prev_wr = 1'b0;

  assign ad_in = (cap_lo ^ 8'h5A) + sc[7:0];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R7: watchdog, got %0d expected %0d clocks max", cyc, 50000);
      summary();
      $finish;
    end
  end

  // monitor: observes the pins and compares against the queue
  always @(negedge clk) if (rst_n) begin
    logic low;
    if (ale) begin
      ale_cnt++;
      chk(bclk == 1'b0, "R11 bclk low during ale", bclk, 0);
      cap_lo = ad_out; cap_hi = a_hi; cap_stat = stat; cap_io = io_m;
      sc = 0; strb = '0; float_ok = 1'b1; post_ok = 1'b1; ready = 1'b1;
      wleft = q.size() > 0 ? int'(q[0].waits) : 0;
    end
    low = !rd_n || !wr_n || !inta_n;
    if (low) begin
      sc++;
      strb |= {~inta_n, ~wr_n, ~rd_n};
      if (sc == 1 && ad_oe) float_ok = 1'b0;
      if (!wr_n) begin
        if (sc >= 2) begin
          wd_last = ad_out;
          if (!ad_oe) float_ok = 1'b0;
        end
      end
      if (!bclk) begin
        if (wleft > 0) begin ready = 1'b0; wleft--; end
        else ready = 1'b1;
      end
    end
    if (!low && prev_low && prev_wr) post_ok = ad_oe && ad_out == wd_last;
    prev_low = low; prev_wr = !wr_n;
    if (done) begin
      if (q.size() == 0) chk(1'b0, "R7 done without request", 1, 0);
      else begin
        item_t e;
        logic [1:0] es;
        logic [2:0] eb;
        e = q.pop_front();
        es = e.kind == 2'b01 ? 2'b01 : e.kind == 2'b10 ? 2'b11 : 2'b10;
        eb = e.kind == 2'b01 ? 3'b010 : e.kind == 2'b10 ? 3'b100 : 3'b001;
        chk(cap_lo == e.addr[7:0], "R2 low address", cap_lo, e.addr[7:0]);
        chk(cap_hi == e.addr[15:8], "R2 high address", cap_hi, e.addr[15:8]);
        chk(cap_stat == es, "R2 status", cap_stat, es);
        chk(cap_io == (e.io | (e.kind == 2'b10)), "R2 io select", cap_io, e.io | (e.kind == 2'b10));
        chk(strb == eb, "R4 strobe select", strb, eb);
        chk(sc == 3 + 2 * int'(e.waits), e.waits == 0 ? "R4 strobe length" : "R5 wait length",
            sc, 3 + 2 * int'(e.waits));
        chk(float_ok, "R3 float then drive in T2", float_ok, 1);
        if (e.kind == 2'b01) begin
          chk(wd_last == e.wd, "R3 write data", wd_last, e.wd);
          chk(post_ok, "R3 write data held after strobe", post_ok, 1);
        end else begin
          logic [7:0] er;
          er = (e.addr[7:0] ^ 8'h5A) + 8'd2 + 8'(2 * int'(e.waits));
          chk(rdata == er, "R6 captured data", rdata, er);
        end
        chk(busy == 1'b0, "R7 busy falls with done", busy, 0);
      end
    end
  end

  // driver: pushes the expected item then pulses req
  task automatic issue(input logic [1:0] k, input logic io, input logic [15:0] a,
                       input logic [7:0] d, input int w);
    while (busy) @(negedge clk);
    q.push_back('{kind: k, io: io, addr: a, wd: d, waits: 4'(w)});
    req = 1'b1; req_kind = k; req_io = io; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain();
    while (busy || q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n, base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ale && rd_n && wr_n && inta_n, "R1 idle control", {ale, rd_n, wr_n, inta_n}, 4'b0111);
    chk(!ad_oe && !hlda && bus_oe, "R1 bus state", {ad_oe, hlda, bus_oe}, 3'b001);
    chk(!busy && !done, "R1 handshake", {busy, done}, 2'b00);

    issue(2'b00, 1'b0, 16'h1234, 8'h00, 0);
    issue(2'b01, 1'b1, 16'h00A7, 8'h56, 0);
    issue(2'b01, 1'b0, 16'h8E31, 8'hC3, 2);
    issue(2'b00, 1'b1, 16'h4F20, 8'h00, 1);
    issue(2'b10, 1'b0, 16'h2B6D, 8'h00, 0);
    issue(2'b00, 1'b0, 16'hFFFF, 8'h00, 3);
    issue(2'b01, 1'b0, 16'h0000, 8'hFF, 1);
    issue(2'b10, 1'b0, 16'h7701, 8'h00, 2);
    drain();

    // R7: second req while busy is ignored
    base = ale_cnt;
    q.push_back('{kind: 2'b00, io: 1'b0, addr: 16'h3C5A, wd: 8'h00, waits: 4'd0});
    req = 1'b1; req_kind = 2'b00; req_addr = 16'h3C5A;
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    req_kind = 2'b01; req_addr = 16'h9999;
    @(negedge clk);
    req = 1'b0;
    drain();
    repeat (8) @(negedge clk);
    chk(ale_cnt == base + 1, "R7 request while busy ignored", ale_cnt - base, 1);

    // R8: hold raised during T2 of a read
    issue(2'b00, 1'b0, 16'h6611, 8'h00, 1);
    while (rd_n) @(negedge clk);
    hold = 1'b1;
    n = 0;
    while (!hlda && n < 20) begin @(negedge clk); n++; end
    chk(rd_n && bus_oe && !done, "R8 grant at mid T3", {rd_n, bus_oe, done}, 3'b110);
    @(negedge clk);
    chk(!bus_oe && !ad_oe && hlda, "R8 float after grant", {bus_oe, ad_oe, hlda}, 3'b001);
    repeat (6) @(negedge clk);
    chk(hlda && !bus_oe, "R9 held", {hlda, bus_oe}, 2'b10);
    hold = 1'b0;
    n = 0;
    while (hlda && n < 10) begin @(negedge clk); n++; end
    chk(n <= 2 && bus_oe, "R9 release at T boundary", n, 2);
    drain();

    // R10: hold granted while idle, wins over a request
    hold = 1'b1;
    n = 0;
    while (!hlda && n < 10) begin @(negedge clk); n++; end
    chk(bus_oe == 1'b1, "R10 bus driven while grant rises", bus_oe, 1);
    @(negedge clk);
    chk(!bus_oe && hlda, "R10 idle grant floats bus", {bus_oe, hlda}, 2'b01);
    base = ale_cnt;
    issue(2'b01, 1'b1, 16'h5E0D, 8'hA5, 0);
    repeat (6) @(negedge clk);
    chk(ale_cnt == base && busy, "R10 request waits during hold", ale_cnt - base, 0);
    hold = 1'b0;
    while (hlda) @(negedge clk);
    chk(bus_oe && !ale, "R9 bus back before cycle", {bus_oe, ale}, 2'b10);
    @(negedge clk);
    @(negedge clk);
    chk(ale == 1'b1, "R9 ale two clocks after release", ale, 1);
    drain();

    summary();
    $finish;
  end
endmodule